// File: doc/BRIEF.md
# Interrupt Trigger-Mode Select and Request Conditioning

This block holds a 16-bit trigger-mode word with one bit for each line of a 16-input interrupt system built from two cascaded controllers. The host reaches the word as two byte-wide registers at adjacent addresses. Each bit selects how its line is turned into a request: as an edge-triggered line, where a rising edge is latched until an end-of-interrupt pulse clears it, or as a level-triggered line, where the request follows the input.

Every raw line first crosses into the clock domain through a two-flop synchronizer. The conditioned request bits are meant to feed a priority and vectoring stage, which is not part of this block. Four lines (0, 1, 2 and 8) are tied to edge mode: the timer and keyboard lines, the cascade input, and the clock line. Software changes one line by reading both bytes, changing the bit, and writing the low byte and then the high byte.

Top module: `irq_trig_ctl`

## Requirements
- R1: Register offset 0 (`host_addr`=0) holds mode bits 7:0 and offset 1 holds mode bits 15:8. `host_rdata` shows, combinationally, the byte selected by `host_addr`. A write (`host_wr`=1 at a clock edge) stores `host_wdata` into the configurable bits of the selected byte, and reads then return the written values.
- R2: A mode bit of 1 puts its line in level mode and 0 puts it in edge mode. Bit n controls `irq_raw[n]` and `irq_req[n]`.
- R3: Bits 0, 1, 2 and 8 ignore writes, always read as 0, and keep their lines in edge mode.
- R4: In edge mode, a 0-to-1 change on `irq_raw[n]`, even one held for a single clock, sets `irq_req[n]`. The request becomes visible after the third rising clock edge following the change and stays set while no end-of-interrupt arrives.
- R5: In edge mode, a one-clock `eoi_clr[n]` clears `irq_req[n]` at the next clock edge. In level mode, `eoi_clr[n]` has no effect on the request.
- R6: In level mode, `irq_req[n]` equals `irq_raw[n]` delayed by two clock edges. It drops when the line deasserts and keeps no memory of earlier pulses.
- R7: Synchronous active-high reset puts every line in edge mode, makes both registers read 0, and clears all requests.
- R8: Switching a line from edge to level mode discards its latched request. On return to edge mode the line starts with no request.
- R9: A write to one byte leaves the other byte unchanged. Cycles without a write leave both bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the mode registers |
| host_addr | input | 1 | Register select: 0 = lines 7:0, 1 = lines 15:8 |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| irq_raw | input | 16 | Raw asynchronous interrupt lines |
| eoi_clr | input | 16 | Per-line end-of-interrupt clear pulse |
| irq_req | output | 16 | Conditioned interrupt requests |

## Verification
The bench writes all-ones to both bytes and checks that bits 0, 1, 2 and 8 still read 0. A design that wrote through to these bits would let the cascade or timer line become level-triggered. It sends single-clock pulses in both modes: an edge line that missed the pulse would lose an interrupt, and a level line that latched it would show a phantom request. It also switches lines between modes while a latched request is pending, which would expose a stale request surviving the change, and it sends end-of-interrupt pulses to level lines, which must leave the request untouched. Random writes, line patterns and clear pulses are checked against a bench model of the mode word and the sticky bits.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    localparam int unsigned LINES   = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned NREG    = LINES / BYTE_W;
    localparam int unsigned ADDR_W  = (NREG > 1) ? $clog2(NREG) : 1;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } host_wr_t;

    // Lines 0..2 and 8 are fixed to edge mode; all others may change mode.
    function automatic logic [LINES-1:0] writable_mask();
        logic [LINES-1:0] m;
        for (int i = 0; i < int'(LINES); i++) begin
            m[i] = !((i <= 2) || (i == 8));
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= raw_in;
            for (int s = 1; s < int'(STAGES); s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (chain[0] == $past(raw_in))); // R6

    AST_SYNC_LAST: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sync_out == $past(chain[(STAGES > 1) ? STAGES-2 : 0]) || STAGES == 1)); // R6
endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
    import irq_trig_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  host_wr_t            hw,
    output logic [BYTE_W-1:0]   rdata,
    output logic [LINES-1:0]    mode_word
);
    localparam logic [LINES-1:0] WMASK = writable_mask();

    logic [LINES-1:0] ctl_q;

    for (genvar r = 0; r < int'(NREG); r++) begin : g_byte
        localparam logic [BYTE_W-1:0] BMASK = WMASK[r*BYTE_W +: BYTE_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[r*BYTE_W +: BYTE_W] <= '0;
            end else if (hw.wr && (hw.addr == ADDR_W'(r))) begin
                ctl_q[r*BYTE_W +: BYTE_W] <= hw.data & BMASK;
            end
        end

        AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
            (hw.wr && hw.addr == ADDR_W'(r)) |=>
            (mode_word[r*BYTE_W +: BYTE_W] == ($past(hw.data) & BMASK))); // R1

        AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !(hw.wr && hw.addr == ADDR_W'(r)) |=>
            $stable(mode_word[r*BYTE_W +: BYTE_W])); // R9
    end

    always_comb begin
        rdata = ctl_q[hw.addr*BYTE_W +: BYTE_W];
    end

    assign mode_word = ctl_q;

    AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_word & ~WMASK) == '0); // R3
endmodule

// File: rtl/irq_req_cond.sv
module irq_req_cond
    import irq_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       lvl,
    input  logic       eoi,
    output logic       req
);
    logic prev_q;
    logic lat_q;
    logic rise;

    assign rise = lvl & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (mode == TRIG_LEVEL) begin
                lat_q <= 1'b0;
            end else if (rise) begin
                lat_q <= 1'b1;
            end else if (eoi) begin
                lat_q <= 1'b0;
            end
        end
    end

    assign req = (mode == TRIG_LEVEL) ? lvl : lat_q;

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && $past(mode) == TRIG_EDGE && $past(req) && !$past(eoi))
        |-> req); // R4

    AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && $past(mode) == TRIG_EDGE && $past(eoi) && !$past(rise))
        |-> !req); // R5

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_LEVEL && !lvl) |-> !req); // R6

    AST_SWITCH_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && $past(mode) == TRIG_LEVEL) |-> !req); // R8
endmodule

// File: rtl/irq_trig_ctl.sv
module irq_trig_ctl
    import irq_trig_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    input  logic [LINES-1:0]    irq_raw,
    input  logic [LINES-1:0]    eoi_clr,
    output logic [LINES-1:0]    irq_req
);
    host_wr_t         hw;
    logic [LINES-1:0] mode_word;
    logic [LINES-1:0] sync_lvl;

    assign hw.wr   = host_wr;
    assign hw.addr = host_addr;
    assign hw.data = host_wdata;

    irq_mode_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .hw        (hw),
        .rdata     (host_rdata),
        .mode_word (mode_word)
    );

    for (genvar n = 0; n < int'(LINES); n++) begin : g_line
        trig_mode_e line_mode;
        assign line_mode = trig_mode_e'(mode_word[n]);

        irq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (irq_raw[n]),
            .sync_out (sync_lvl[n])
        );

        irq_req_cond u_cond (
            .clk  (clk),
            .rst  (rst),
            .mode (line_mode),
            .lvl  (sync_lvl[n]),
            .eoi  (eoi_clr[n]),
            .req  (irq_req[n])
        );
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (mode_word == '0 && irq_req == '0)); // R7
endmodule

// File: tb/irq_trig_ctl_tb.sv
`timescale 1ns/1ps
module irq_trig_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [0:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [15:0] irq_raw = '0;
    logic [15:0] eoi_clr = '0;
    logic [15:0] irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [15:0] WMASK = 16'hFEF8;
    logic [15:0] exp_ctl = '0;
    logic [15:0] sticky  = '0;
    logic [15:0] cur_raw = '0;

    always #2.5 clk = ~clk;

    irq_trig_ctl dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_raw(irq_raw),
        .eoi_clr(eoi_clr), .irq_req(irq_req)
    );

    function automatic logic [15:0] exp_req(logic [15:0] ctl, logic [15:0] raw, logic [15:0] st);
        return (ctl & raw) | (~ctl & st);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_req(string tag);
        chk(tag, irq_req, exp_req(exp_ctl, cur_raw, sticky));
    endtask

    task automatic check_regs(string tag);
        host_addr = 1'b0; #0.5;
        chk(tag, {8'h00, host_rdata}, {8'h00, exp_ctl[7:0]});
        host_addr = 1'b1; #0.5;
        chk(tag, {8'h00, host_rdata}, {8'h00, exp_ctl[15:8]});
    endtask

    task automatic write_reg(logic a, logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (a) exp_ctl[15:8] = d & WMASK[15:8];
        else   exp_ctl[7:0]  = d & WMASK[7:0];
        sticky &= ~exp_ctl;
    endtask

    task automatic set_raw(logic [15:0] v);
        @(negedge clk);
        sticky |= v & ~cur_raw & ~exp_ctl;
        irq_raw = v; cur_raw = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_eoi(logic [15:0] v);
        @(negedge clk);
        eoi_clr = v;
        @(negedge clk);
        eoi_clr = '0;
        sticky &= ~(v & ~exp_ctl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_regs("R7 reset regs");
        chk("R7 reset req", irq_req, 16'h0000);

        // R3: fixed bits
        write_reg(1'b0, 8'hFF);
        write_reg(1'b1, 8'hFF);
        check_regs("R3 fixed bits read zero");
        chk("R3 fixed value", {8'h00, exp_ctl[7:0]}, 16'h00F8);

        // R9: independent bytes
        write_reg(1'b0, 8'h28);
        check_regs("R9 high byte untouched");
        write_reg(1'b1, 8'h00);
        check_regs("R1 byte readback");

        // R6 level line 3 (bit 3=1), R4 edge line 4
        set_raw(16'h0018);
        chk("R6 level follows", irq_req & 16'h0008, 16'h0008);
        chk("R4 edge latched", irq_req & 16'h0010, 16'h0010);
        set_raw(16'h0000);
        chk("R6 level drops", irq_req & 16'h0008, 16'h0000);
        chk("R4 edge sticky", irq_req & 16'h0010, 16'h0010);

        // R4 timing: visible after third edge, not second
        @(negedge clk); irq_raw = 16'h0040;
        repeat (2) @(negedge clk);
        chk("R4 not yet after two edges", irq_req & 16'h0040, 16'h0000);
        @(negedge clk);
        chk("R4 visible after three edges", irq_req & 16'h0040, 16'h0040);
        sticky |= 16'h0040; cur_raw = 16'h0040;
        set_raw(16'h0000);

        // R6 timing: level visible after two edges
        @(negedge clk); irq_raw = 16'h0008;
        @(negedge clk);
        chk("R6 not after one edge", irq_req & 16'h0008, 16'h0000);
        @(negedge clk);
        chk("R6 after two edges", irq_req & 16'h0008, 16'h0008);
        cur_raw = 16'h0008;
        set_raw(16'h0000);

        // Single-cycle pulses: edge line 7, level line 5
        @(negedge clk); irq_raw = 16'h00A0;
        @(negedge clk); irq_raw = 16'h0000;
        repeat (4) @(negedge clk);
        sticky |= 16'h0080;
        check_req("R4 single pulse edge, R6 level no memory");

        // R5 eoi clears edge, not level
        pulse_eoi(16'h00D0);
        check_req("R5 eoi clears edge");
        set_raw(16'h0008);
        pulse_eoi(16'h0008);
        chk("R5 eoi ignored in level", irq_req & 16'h0008, 16'h0008);
        set_raw(16'h0000);

        // R8 switch with pending request
        set_raw(16'h0200); set_raw(16'h0000);
        chk("R8 pending edge", irq_req & 16'h0200, 16'h0200);
        write_reg(1'b1, 8'h02);
        chk("R8 discard on level", irq_req & 16'h0200, 16'h0000);
        write_reg(1'b1, 8'h00);
        chk("R8 no request on return R2", irq_req & 16'h0200, 16'h0000);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: begin
                    write_reg(1'($urandom_range(0, 1)), 8'($urandom));
                    check_regs("R1 random readback");
                    check_req("R8 random mode change");
                end
                1, 2: begin
                    set_raw(16'($urandom));
                    check_req("R2 random lines R4 R6");
                end
                default: begin
                    pulse_eoi(16'($urandom));
                    check_req("R5 random eoi");
                end
            endcase
        end

        // R7 reset mid-run
        set_raw(16'h0000);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_ctl = '0; sticky = '0;
        @(negedge clk);
        check_regs("R7 reset regs again");
        chk("R7 reset req again", irq_req, 16'h0000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule